// File: doc/BRIEF.md
# Stack Context Sequencer

This block holds the 16-bit stack pointer of an 8-bit processor. It turns save and restore requests into a sequence of byte writes and reads on a single-port memory. A subroutine call stores a two-byte return address. Interrupt entry stores a five-byte context. The matching return requests read those bytes back into output registers. Single-byte push and pull, and a direct load of the pointer, complete the set of operations.

Each request is a one-cycle strobe. When the sequencer is idle it accepts a request and copies the register values it has to save. It then moves one byte per clock cycle, with `busy` high, until the whole frame has been written or read. The pointer can address the full 64 KB space. A write goes to the address in the pointer, and the pointer then moves down. A read first moves the pointer up and then reads from the new address. The upper index register is never part of the interrupt context, so there is no port for it.

Top module: `stack_seq`

## Requirements
- R1: After reset `spOut` is 0x00FF, `busy` and `memWe` are 0, and `pcOut`, `xOut`, `aOut`, `ccOut` and `pullData` are 0.
- R2: Each byte written drives `memAddr` equal to the current pointer with `memWe` high, and the pointer is one lower in the next cycle.
- R3: Each byte read drives `memAddr` equal to the pointer plus one with `memWe` low, and the pointer is one higher in the next cycle.
- R4: A call writes two bytes, the PC low byte at the starting pointer and the PC high byte one below it, and leaves the pointer lowered by 2.
- R5: A return reads two bytes, PC high first and then PC low, into `pcOut`, and leaves the pointer raised by 2.
- R6: Interrupt entry writes five bytes in the order PC low, PC high, X, A, CC, from the starting pointer downward, and leaves the pointer lowered by 5.
- R7: Interrupt return reads five bytes in the order CC, A, X, PC high, PC low into the matching outputs, and leaves the pointer raised by 5.
- R8: A single push writes `pushData` and lowers the pointer by 1. A single pull loads `pullData` and raises the pointer by 1.
- R9: A load request while idle, with no frame request in the same cycle, sets the pointer to `loadVal` in the next cycle.
- R10: A load request is ignored while `busy` is high, and also in a cycle where a frame request is accepted.
- R11: When several frame requests arrive in the same idle cycle, one is served, by priority from highest to lowest: interrupt entry, call, interrupt return, return, push, pull. Requests that arrive while `busy` is high are ignored.
- R12: `busy` rises in the cycle after the request is accepted and stays high for exactly the frame length (2, 5, 2, 5, 1 or 1 cycles). `memWe` is never high while `busy` is low.
- R13: The values written are those present on `pcIn`, `xIn`, `aIn`, `ccIn` and `pushData` in the accepting cycle. Later changes to these inputs do not affect the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Start a two-byte call frame |
| retReq | input | 1 | Start a two-byte return |
| irqReq | input | 1 | Start a five-byte interrupt frame |
| rtiReq | input | 1 | Start a five-byte interrupt return |
| pushReq | input | 1 | Push one byte |
| pullReq | input | 1 | Pull one byte |
| loadReq | input | 1 | Replace the stack pointer |
| loadVal | input | 16 | New stack pointer value |
| pcIn | input | 16 | Program counter to save |
| xIn | input | 8 | X register to save |
| aIn | input | 8 | Accumulator to save |
| ccIn | input | 8 | Condition codes to save |
| pushData | input | 8 | Byte for a single push |
| memRdata | input | 8 | Read data from memory at memAddr, same cycle |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| busy | output | 1 | Frame transfer in progress |
| spOut | output | 16 | Current stack pointer |
| pcOut | output | 16 | Restored program counter |
| xOut | output | 8 | Restored X |
| aOut | output | 8 | Restored accumulator |
| ccOut | output | 8 | Restored condition codes |
| pullData | output | 8 | Byte from the last single pull |

## Verification
A pointer load can land in the same cycle as the start of a frame. It can also land inside a frame, where the pointer is already stepping one byte per cycle. The bench covers the first case by raising load together with interrupt entry and call. It covers the second by pulsing load during a call frame. In both cases it judges the result from the final `spOut`, the number of `busy` cycles and the bytes left in memory, none of which may show `loadVal`. Competing frame requests, such as interrupt return together with pull, are checked the same way against the frame length of the higher-priority request.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_CALL = 3'd0,
    OP_RET  = 3'd1,
    OP_IRQ  = 3'd2,
    OP_RTI  = 3'd3,
    OP_PUSH = 3'd4,
    OP_PULL = 3'd5
  } frameOp_t;

  // which saved or restored byte a transfer step handles
  typedef enum logic [2:0] {
    SEL_PCL  = 3'd0,
    SEL_PCH  = 3'd1,
    SEL_X    = 3'd2,
    SEL_A    = 3'd3,
    SEL_CC   = 3'd4,
    SEL_DATA = 3'd5
  } byteSel_t;

  typedef struct packed {
    logic     capture;  // snapshot register inputs
    logic     write;    // push one byte this cycle
    logic     read;     // pull one byte this cycle
    byteSel_t sel;
    logic     loadSp;   // replace pointer
  } stackStrobe_t;

  function automatic logic [2:0] frameLen(frameOp_t op);
    case (op)
      OP_CALL, OP_RET: frameLen = 3'd2;
      OP_IRQ, OP_RTI:  frameLen = 3'd5;
      default:         frameLen = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         callReq,
  input  logic         retReq,
  input  logic         irqReq,
  input  logic         rtiReq,
  input  logic         pushReq,
  input  logic         pullReq,
  input  logic         loadReq,
  output stackStrobe_t strobe,
  output logic         busy
);

  logic     active;
  frameOp_t op;
  frameOp_t newOp;
  logic [2:0] step;
  logic     anyReq;
  logic     isWriteOp;

  always_comb begin
    anyReq = irqReq | callReq | rtiReq | retReq | pushReq | pullReq;
    if (irqReq)       newOp = OP_IRQ;
    else if (callReq) newOp = OP_CALL;
    else if (rtiReq)  newOp = OP_RTI;
    else if (retReq)  newOp = OP_RET;
    else if (pushReq) newOp = OP_PUSH;
    else              newOp = OP_PULL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      op     <= OP_CALL;
      step   <= 3'd0;
    end else if (!active) begin
      if (anyReq) begin
        active <= 1'b1;
        op     <= newOp;
        step   <= 3'd0;
      end
    end else if (step == frameLen(op) - 3'd1) begin
      active <= 1'b0;
      step   <= 3'd0;
    end else begin
      step <= step + 3'd1;
    end
  end

  always_comb begin
    isWriteOp = (op == OP_CALL) || (op == OP_IRQ) || (op == OP_PUSH);
    strobe.capture = !active && anyReq;
    strobe.loadSp  = !active && !anyReq && loadReq;
    strobe.write   = active && isWriteOp;
    strobe.read    = active && !isWriteOp;
    case (op)
      OP_CALL, OP_IRQ: strobe.sel = byteSel_t'(step);
      OP_RET:          strobe.sel = byteSel_t'(3'd1 - step);
      OP_RTI:          strobe.sel = byteSel_t'(3'd4 - step);
      default:         strobe.sel = SEL_DATA;
    endcase
  end

  assign busy = active;

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h00FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  stackStrobe_t        strobe,
  input  logic [ADDR_W-1:0]   loadVal,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   xIn,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   ccIn,
  input  logic [DATA_W-1:0]   pushData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic [ADDR_W-1:0]   spOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   xOut,
  output logic [DATA_W-1:0]   aOut,
  output logic [DATA_W-1:0]   ccOut,
  output logic [DATA_W-1:0]   pullData
);

  localparam int PC_W = 2 * DATA_W;

  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] spInc;
  logic [PC_W-1:0]   pcSnap;
  logic [DATA_W-1:0] xSnap, aSnap, ccSnap, datSnap;

  assign spInc = sp + ADDR_W'(1);

  always_comb begin
    memWe   = strobe.write;
    memAddr = strobe.read ? spInc : sp;
    case (strobe.sel)
      SEL_PCL: memWdata = pcSnap[DATA_W-1:0];
      SEL_PCH: memWdata = pcSnap[PC_W-1:DATA_W];
      SEL_X:   memWdata = xSnap;
      SEL_A:   memWdata = aSnap;
      SEL_CC:  memWdata = ccSnap;
      default: memWdata = datSnap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp       <= RESET_SP;
      pcSnap   <= '0;
      xSnap    <= '0;
      aSnap    <= '0;
      ccSnap   <= '0;
      datSnap  <= '0;
      pcOut    <= '0;
      xOut     <= '0;
      aOut     <= '0;
      ccOut    <= '0;
      pullData <= '0;
    end else begin
      if (strobe.capture) begin
        pcSnap  <= pcIn;
        xSnap   <= xIn;
        aSnap   <= aIn;
        ccSnap  <= ccIn;
        datSnap <= pushData;
      end
      if (strobe.loadSp) begin
        sp <= loadVal;
      end else if (strobe.write) begin
        sp <= sp - ADDR_W'(1);
      end else if (strobe.read) begin
        sp <= spInc;
        case (strobe.sel)
          SEL_PCL: pcOut[DATA_W-1:0]    <= memRdata;
          SEL_PCH: pcOut[PC_W-1:DATA_W] <= memRdata;
          SEL_X:   xOut     <= memRdata;
          SEL_A:   aOut     <= memRdata;
          SEL_CC:  ccOut    <= memRdata;
          default: pullData <= memRdata;
        endcase
      end
    end
  end

  assign spOut = sp;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h00FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                callReq,
  input  logic                retReq,
  input  logic                irqReq,
  input  logic                rtiReq,
  input  logic                pushReq,
  input  logic                pullReq,
  input  logic                loadReq,
  input  logic [ADDR_W-1:0]   loadVal,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   xIn,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   ccIn,
  input  logic [DATA_W-1:0]   pushData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic                busy,
  output logic [ADDR_W-1:0]   spOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   xOut,
  output logic [DATA_W-1:0]   aOut,
  output logic [DATA_W-1:0]   ccOut,
  output logic [DATA_W-1:0]   pullData
);

  stackStrobe_t strobe;

  stack_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .callReq(callReq), .retReq(retReq), .irqReq(irqReq), .rtiReq(rtiReq),
    .pushReq(pushReq), .pullReq(pullReq), .loadReq(loadReq),
    .strobe(strobe), .busy(busy)
  );

  stack_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_SP(RESET_SP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadVal(loadVal), .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .ccIn(ccIn),
    .pushData(pushData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .spOut(spOut), .pcOut(pcOut), .xOut(xOut), .aOut(aOut), .ccOut(ccOut),
    .pullData(pullData)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              callReq,
  input logic              retReq,
  input logic              irqReq,
  input logic              rtiReq,
  input logic              pushReq,
  input logic              pullReq,
  input logic              loadReq,
  input logic [ADDR_W-1:0] loadVal,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              busy,
  input logic [ADDR_W-1:0] spOut
);

  logic anyReq;
  assign anyReq = callReq | retReq | irqReq | rtiReq | pushReq | pullReq;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);  // R12
  AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == spOut);  // R2
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == ADDR_W'($past(spOut) - ADDR_W'(1)));  // R2
  AST_PULL_ABOVE_SP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memWe) |-> memAddr == ADDR_W'(spOut + ADDR_W'(1)));  // R3
  AST_PULL_INC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memWe) |=> spOut == ADDR_W'($past(spOut) + ADDR_W'(1)));  // R3
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadReq && !anyReq) |=> spOut == $past(loadVal));  // R9
  AST_LOAD_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && loadReq && memWe) |=> spOut == ADDR_W'($past(spOut) - ADDR_W'(1)));  // R10
  AST_IDLE_SP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyReq && !loadReq) |=> $stable(spOut));  // R9

endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .callReq(callReq), .retReq(retReq), .irqReq(irqReq), .rtiReq(rtiReq),
  .pushReq(pushReq), .pullReq(pullReq), .loadReq(loadReq), .loadVal(loadVal),
  .memAddr(memAddr), .memWe(memWe), .busy(busy), .spOut(spOut)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic callReq = 0, retReq = 0, irqReq = 0, rtiReq = 0, pushReq = 0, pullReq = 0, loadReq = 0;
  logic [15:0] loadVal = '0, pcIn = '0;
  logic [7:0]  xIn = '0, aIn = '0, ccIn = '0, pushData = '0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr, spOut, pcOut;
  logic [7:0]  memWdata, xOut, aOut, ccOut, pullData;
  logic        memWe, busy;

  logic [7:0] mem [0:1023];
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;
  assign memRdata = mem[memAddr[9:0]];

  stack_seq uut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq), .irqReq(irqReq),
    .rtiReq(rtiReq), .pushReq(pushReq), .pullReq(pullReq), .loadReq(loadReq),
    .loadVal(loadVal), .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .ccIn(ccIn),
    .pushData(pushData), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .busy(busy), .spOut(spOut), .pcOut(pcOut), .xOut(xOut),
    .aOut(aOut), .ccOut(ccOut), .pullData(pullData)
  );

  // kinds: 0 load, 1 call, 2 ret, 3 irq, 4 rti, 5 push, 6 pull
  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] val;
    logic [15:0] pc;
    logic [7:0]  x, a, cc, dat;
    logic [15:0] expSp, expPc;
    logic [7:0]  expX, expA, expCc, expPull;
    logic [2:0]  expLen;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'h0300, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0300, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0},
    '{3'd1, 16'h0000, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h00, 16'h02FE, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 3'd2},
    '{3'd3, 16'h0000, 16'hABCD, 8'h11, 8'h22, 8'h33, 8'h00, 16'h02F9, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 3'd5},
    '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h5A, 16'h02F8, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1},
    '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h02F9, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd1},
    '{3'd4, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h02FE, 16'hABCD, 8'h11, 8'h22, 8'h33, 8'h5A, 3'd5},
    '{3'd2, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0300, 16'h1234, 8'h11, 8'h22, 8'h33, 8'h5A, 3'd2},
    '{3'd0, 16'h0100, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0100, 16'h1234, 8'h11, 8'h22, 8'h33, 8'h5A, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // pulse the requests named by mask for one cycle, return busy length
  task automatic fire(input logic [6:0] mask, output int len);
    @(negedge clk);
    loadReq = mask[0]; callReq = mask[1]; retReq = mask[2]; irqReq = mask[3];
    rtiReq = mask[4]; pushReq = mask[5]; pullReq = mask[6];
    @(negedge clk);
    {loadReq, callReq, retReq, irqReq, rtiReq, pushReq, pullReq} = '0;
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int len;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sp", spOut, 32'h00FF);
    check("R1 busy", busy, 0);
    check("R1 memWe", memWe, 0);
    check("R1 pcOut", pcOut, 0);
    rstN = 1'b1;

    for (int v = 0; v < 8; v++) begin
      loadVal = VECS[v].val; pcIn = VECS[v].pc; xIn = VECS[v].x;
      aIn = VECS[v].a; ccIn = VECS[v].cc; pushData = VECS[v].dat;
      fire(7'(1) << VECS[v].kind, len);
      check("R12 len", len, VECS[v].expLen);
      check("R4 R5 R6 R7 R8 R9 sp", spOut, VECS[v].expSp);
      check("R5 R7 pc", pcOut, VECS[v].expPc);
      check("R7 x", xOut, VECS[v].expX);
      check("R7 a", aOut, VECS[v].expA);
      check("R7 cc", ccOut, VECS[v].expCc);
      check("R8 pull", pullData, VECS[v].expPull);
      if (v == 2) begin
        // R4 call bytes and R6 interrupt frame order
        check("R4 pcl", mem[10'h300], 8'h34);
        check("R4 pch", mem[10'h2FF], 8'h12);
        check("R6 pcl", mem[10'h2FE], 8'hCD);
        check("R6 pch", mem[10'h2FD], 8'hAB);
        check("R6 x", mem[10'h2FC], 8'h11);
        check("R6 a", mem[10'h2FB], 8'h22);
        check("R6 cc", mem[10'h2FA], 8'h33);
      end
      if (v == 3) check("R8 push byte", mem[10'h2F9], 8'h5A);
    end

    // R2 / R3 addressing during a push and a pull
    pushData = 8'h77;
    @(negedge clk); pushReq = 1;
    @(negedge clk); pushReq = 0;
    check("R2 we", memWe, 1);
    check("R2 addr", memAddr, 32'h0100);
    check("R2 data", memWdata, 8'h77);
    @(negedge clk);
    check("R2 sp dec", spOut, 32'h00FF);
    pullReq = 1;
    @(negedge clk); pullReq = 0;
    check("R3 addr", memAddr, 32'h0100);
    check("R3 we", memWe, 0);
    @(negedge clk);
    check("R3 sp inc", spOut, 32'h0100);
    check("R3 data", pullData, 8'h77);

    // R10 load during a frame ignored; R13 inputs captured at accept
    pcIn = 16'h5566; loadVal = 16'h0200;
    @(negedge clk); callReq = 1;
    @(negedge clk); callReq = 0; loadReq = 1; pcIn = 16'h9999;
    @(negedge clk); loadReq = 0;
    while (busy) @(negedge clk);
    check("R10 sp busy load", spOut, 32'h00FE);
    check("R13 pcl", mem[10'h100], 8'h66);
    check("R13 pch", mem[10'h0FF], 8'h55);

    // R11 irq beats call and load in one cycle; load lost (R10)
    pcIn = 16'h0A0B; xIn = 8'h44; aIn = 8'h55; ccIn = 8'h66; loadVal = 16'h0300;
    fire(7'b0001011, len);
    check("R11 irq len", len, 5);
    check("R10 R11 sp", spOut, 32'h00F9);
    check("R11 first byte", mem[10'h0FE], 8'h0B);
    check("R11 last byte", mem[10'h0FA], 8'h66);

    // R11 rti beats pull
    fire(7'b1010000, len);
    check("R11 rti len", len, 5);
    check("R11 rti sp", spOut, 32'h00FE);
    check("R11 rti pc", pcOut, 32'h0A0B);
    check("R11 rti cc", ccOut, 8'h66);

    // R11 request while busy is ignored
    @(negedge clk); pushReq = 1;
    @(negedge clk); pushReq = 0; pullReq = 1;
    @(negedge clk); pullReq = 0;
    @(negedge clk);
    check("R11 busy pull ignored", spOut, 32'h00FD);
    check("R12 idle", busy, 0);

    summary();
  end

endmodule